// File: doc/BRIEF.md
# Pushbutton power sequencing controller

This synchronous controller decides when a system's power rails are enabled, driven by a momentary active-low pushbutton and a digital undervoltage flag. A held press while the system is off turns the enable on. A processor then has a fixed blanking window in which to raise its kill line. After that window, the processor owns shutdown through that line.

While the system runs, a fresh press or a persistent undervoltage condition pulls the interrupt line low. This asks the processor to shut down in an orderly way. If the processor never acts and the cause persists long enough, the controller drops the enable by itself.

All timing is counted in pulses of a one-millisecond tick input. The forced power-down window is a fixed minimum plus a delay supplied on an input port. The enable polarity is chosen by a parameter.

Top module: `pbpwr_ctrl`

## Requirements
- R1: After synchronous reset the unit is off: the enable is inactive (pwr_en low when EN_ACT_HIGH=1) and irq_n is high.
- R2: While off, with uv_ok high, holding pb_n low for DB_ON_MS ticks (default 32) activates the enable. A shorter hold does not.
- R3: While uv_ok is low, a press never activates the enable. A press detected during this lockout must be released before it can count, even if uv_ok returns high while the button is held.
- R4: kill_n is ignored for BLANK_MS ticks (default 512) after turn-on. If kill_n is low when that window ends, the enable is released. If kill_n is high, the unit enters normal operation.
- R5: In normal operation, with or without the interrupt active, kill_n low releases the enable and the interrupt on the next clock.
- R6: In normal operation, a press held DB_OFF_MS ticks (default 32) drives irq_n low while the enable stays active. The press that turned the unit on must be released first.
- R7: In normal operation, uv_ok low for UV_MS ticks (default 32) drives irq_n low while the enable stays active.
- R8: Once low, irq_n stays low for at least INT_MIN_MS ticks (default 32). It also stays low while pb_n is low or uv_ok is low. It then returns high with the enable still active.
- R9: While the interrupt is active, pb_n or uv_ok held low for PD_MIN_MS (default 64) plus extra_dly_ms ticks, counted from the start of that low level, releases both the enable and the interrupt.
- R10: After any power-down, the unit stays off while pb_n remains low. A new turn-on needs a release and then a fresh press.
- R11: With EN_ACT_HIGH=0, pwr_en is the inverse of the EN_ACT_HIGH=1 variant under the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pb_n | input | 1 | Pushbutton, low while pressed |
| uv_ok | input | 1 | Undervoltage comparator result, low means undervoltage |
| kill_n | input | 1 | Processor kill line, low requests power off |
| extra_dly_ms | input | DLYW | Extra forced power-down delay in ticks |
| pwr_en | output | 1 | Power enable, polarity set by EN_ACT_HIGH |
| irq_n | output | 1 | Shutdown request, active low |

## Verification
On every cycle the assertions check four things. The undervoltage lockout holds while off. A kill in normal operation drops the enable one clock later. An active interrupt always comes with an active enable. Each enable rise follows a held press. A further check confirms that an interrupt ending with power still on lasted its minimum tick count. Only the bench scenarios can show the exact debounce, blanking and forced power-down tick thresholds, the release-before-repress rule and the polarity variant, since these depend on long stimulus histories.

// File: rtl/pbpwr_pkg.sv
package pbpwr_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WREL  = 3'd1,
        ST_BLANK = 3'd2,
        ST_ON    = 3'd3,
        ST_IRQ   = 3'd4
    } pwr_st_t;

    typedef struct packed {
        logic en_on;
        logic irq_act;
    } pwr_out_t;

    function automatic pwr_out_t decode_out(pwr_st_t s);
        pwr_out_t o;
        o.en_on   = (s == ST_BLANK) || (s == ST_ON) || (s == ST_IRQ);
        o.irq_act = (s == ST_IRQ);
        return o;
    endfunction

endpackage

// File: rtl/pbpwr_lowtimer.sv
module pbpwr_lowtimer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ms_tick,
    input  logic          lvl_n,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || lvl_n) begin
            cnt <= '0;
        end else if (ms_tick && cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pbpwr_fsm.sv
module pbpwr_fsm
    import pbpwr_pkg::*;
#(
    parameter int CW         = 10,
    parameter int TW         = 11,
    parameter int DLYW       = 8,
    parameter int DB_ON_MS   = 32,
    parameter int DB_OFF_MS  = 32,
    parameter int UV_MS      = 32,
    parameter int BLANK_MS   = 512,
    parameter int PD_MIN_MS  = 64,
    parameter int INT_MIN_MS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            pb_n,
    input  logic            uv_ok,
    input  logic            kill_n,
    input  logic [DLYW-1:0] extra_dly_ms,
    input  logic [CW-1:0]   pb_cnt,
    input  logic [CW-1:0]   uv_cnt,
    output pwr_st_t         st
);
    localparam logic [CW-1:0] DBON_T = CW'(DB_ON_MS);
    localparam logic [CW-1:0] DBOF_T = CW'(DB_OFF_MS);
    localparam logic [CW-1:0] UV_T   = CW'(UV_MS);
    localparam logic [TW-1:0] BLK_T  = TW'(BLANK_MS);
    localparam logic [TW-1:0] INT_T  = TW'(INT_MIN_MS);
    localparam logic [TW-1:0] TMAX   = {TW{1'b1}};

    pwr_st_t       nxt;
    logic [TW-1:0] tcnt;
    logic          tclr;
    logic          need_rel;
    logic [CW-1:0] pd_t;

    assign pd_t = CW'(PD_MIN_MS) + CW'(extra_dly_ms);

    always_comb begin
        nxt  = st;
        tclr = 1'b0;
        unique case (st)
            ST_OFF: begin
                if (pb_cnt >= DBON_T) begin
                    nxt  = uv_ok ? ST_BLANK : ST_WREL;
                    tclr = 1'b1;
                end
            end
            ST_WREL: begin
                if (pb_n) nxt = ST_OFF;
            end
            ST_BLANK: begin
                if (tcnt >= BLK_T) nxt = kill_n ? ST_ON : ST_WREL;
            end
            ST_ON: begin
                if (!kill_n) begin
                    nxt = ST_WREL;
                end else if ((pb_cnt >= DBOF_T && !need_rel) || uv_cnt >= UV_T) begin
                    nxt  = ST_IRQ;
                    tclr = 1'b1;
                end
            end
            ST_IRQ: begin
                if (!kill_n || pb_cnt >= pd_t || uv_cnt >= pd_t) begin
                    nxt = ST_WREL;
                end else if (tcnt >= INT_T && pb_n && uv_ok) begin
                    nxt = ST_ON;
                end
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_OFF;
            tcnt     <= '0;
            need_rel <= 1'b0;
        end else begin
            st <= nxt;
            if (tclr) begin
                tcnt <= '0;
            end else if (ms_tick && tcnt != TMAX) begin
                tcnt <= tcnt + 1'b1;
            end
            if (st == ST_OFF && nxt == ST_BLANK) begin
                need_rel <= 1'b1;
            end else if (pb_n) begin
                need_rel <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pbpwr_ctrl.sv
module pbpwr_ctrl
    import pbpwr_pkg::*;
#(
    parameter int DLYW        = 8,
    parameter int DB_ON_MS    = 32,
    parameter int DB_OFF_MS   = 32,
    parameter int UV_MS       = 32,
    parameter int BLANK_MS    = 512,
    parameter int PD_MIN_MS   = 64,
    parameter int INT_MIN_MS  = 32,
    parameter bit EN_ACT_HIGH = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            pb_n,
    input  logic            uv_ok,
    input  logic            kill_n,
    input  logic [DLYW-1:0] extra_dly_ms,
    output logic            pwr_en,
    output logic            irq_n
);
    localparam int CW = $clog2(PD_MIN_MS + (1 << DLYW)) + 1;
    localparam int TW = $clog2(BLANK_MS + INT_MIN_MS + 1) + 1;

    logic [CW-1:0] pb_cnt;
    logic [CW-1:0] uv_cnt;
    pwr_st_t       st;
    pwr_out_t      outs;
    logic          en_on;

    pbpwr_lowtimer #(.CW(CW)) u_pb_tmr (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .lvl_n(pb_n), .cnt(pb_cnt)
    );

    pbpwr_lowtimer #(.CW(CW)) u_uv_tmr (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .lvl_n(uv_ok), .cnt(uv_cnt)
    );

    pbpwr_fsm #(
        .CW(CW), .TW(TW), .DLYW(DLYW),
        .DB_ON_MS(DB_ON_MS), .DB_OFF_MS(DB_OFF_MS), .UV_MS(UV_MS),
        .BLANK_MS(BLANK_MS), .PD_MIN_MS(PD_MIN_MS), .INT_MIN_MS(INT_MIN_MS)
    ) u_fsm (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pb_n(pb_n), .uv_ok(uv_ok),
        .kill_n(kill_n), .extra_dly_ms(extra_dly_ms),
        .pb_cnt(pb_cnt), .uv_cnt(uv_cnt), .st(st)
    );

    assign outs  = decode_out(st);
    assign en_on = outs.en_on;
    assign irq_n = ~outs.irq_act;

    generate
        if (EN_ACT_HIGH) begin : g_en_hi
            assign pwr_en = en_on;
        end else begin : g_en_lo
            assign pwr_en = ~en_on;
        end
    endgenerate
endmodule

// File: rtl/pbpwr_chk.sv
module pbpwr_chk
    import pbpwr_pkg::*;
#(
    parameter int INT_MIN_MS = 32
) (
    input logic    clk,
    input logic    rst,
    input logic    ms_tick,
    input logic    pb_n,
    input logic    uv_ok,
    input logic    kill_n,
    input logic    irq_n,
    input logic    en_on,
    input pwr_st_t st
);
    logic [15:0] irq_ticks;

    always_ff @(posedge clk) begin
        if (rst || irq_n) begin
            irq_ticks <= '0;
        end else if (ms_tick && irq_ticks != 16'hFFFF) begin
            irq_ticks <= irq_ticks + 1'b1;
        end
    end

    p_rst_off_r1: assert property (@(posedge clk) rst |=> (!en_on && irq_n));

    p_en_press_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(en_on) |-> !$past(pb_n));

    p_lockout_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OFF && !uv_ok) |=> !en_on);

    p_kill_off_r5: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_ON || st == ST_IRQ) && !kill_n) |=> (!en_on && irq_n));

    p_irq_en_r6: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> en_on);

    p_irq_min_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_n) && en_on) |-> (irq_ticks >= 16'(INT_MIN_MS)));
endmodule

bind pbpwr_ctrl pbpwr_chk #(.INT_MIN_MS(INT_MIN_MS)) u_chk (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pb_n(pb_n), .uv_ok(uv_ok),
    .kill_n(kill_n), .irq_n(irq_n), .en_on(en_on), .st(st)
);

// File: tb/pbpwr_ctrl_test.sv
`timescale 1ns/1ps
module pbpwr_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       pb_n = 1'b1;
    logic       uv_ok = 1'b1;
    logic       kill_n = 1'b0;
    logic [7:0] extra_dly_ms = 8'd16;
    logic       pwr_en, irq_n, pwr_en_lo, irq_n_lo;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbpwr_ctrl uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pb_n(pb_n), .uv_ok(uv_ok),
        .kill_n(kill_n), .extra_dly_ms(extra_dly_ms), .pwr_en(pwr_en), .irq_n(irq_n)
    );

    pbpwr_ctrl #(.EN_ACT_HIGH(1'b0)) uut_lo (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pb_n(pb_n), .uv_ok(uv_ok),
        .kill_n(kill_n), .extra_dly_ms(extra_dly_ms), .pwr_en(pwr_en_lo), .irq_n(irq_n_lo)
    );

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            ms_tick <= 1'b1;
            @(posedge clk);
            ms_tick <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic en_exp, input logic irq_exp);
        chk(pwr_en == en_exp, {tag, " pwr_en"}, int'(pwr_en), int'(en_exp));
        chk(irq_n == irq_exp, {tag, " irq_n"}, int'(irq_n), int'(irq_exp));
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic power_up();
        kill_n = 1'b1;
        pb_n = 1'b0;
        wait_ticks(34);
        chk_out("R2 turn-on", 1'b1, 1'b1);
        chk(pwr_en_lo == 1'b0, "R11 low-polarity on", int'(pwr_en_lo), 0);
        pb_n = 1'b1;
        wait_ticks(500);
        chk_out("R4 blank with kill high", 1'b1, 1'b1);
        wait_ticks(20);
        chk_out("R4 normal after blank", 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_out("R1 reset", 1'b0, 1'b1);
        chk(pwr_en_lo == 1'b1, "R11 low-polarity reset", int'(pwr_en_lo), 1);
    endtask

    task automatic t_lockout();
        uv_ok = 1'b0;
        pb_n = 1'b0;
        wait_ticks(40);
        chk_out("R3 lockout press", 1'b0, 1'b1);
        uv_ok = 1'b1;
        wait_ticks(40);
        chk_out("R3 held press after uv recovery", 1'b0, 1'b1);
        pb_n = 1'b1;
        wait_ticks(2);
    endtask

    task automatic t_turn_on_kill_low();
        kill_n = 1'b0;
        pb_n = 1'b0;
        wait_ticks(30);
        chk_out("R2 short hold", 1'b0, 1'b1);
        wait_ticks(4);
        chk_out("R2 debounced hold", 1'b1, 1'b1);
        pb_n = 1'b1;
        wait_ticks(480);
        chk_out("R4 kill ignored in blank", 1'b1, 1'b1);
        wait_ticks(40);
        chk_out("R4 kill low at blank end", 1'b0, 1'b1);
        chk(pwr_en_lo == 1'b1, "R11 low-polarity off", int'(pwr_en_lo), 1);
    endtask

    task automatic t_press_irq();
        pb_n = 1'b0;
        wait_ticks(30);
        chk_out("R6 short press", 1'b1, 1'b1);
        wait_ticks(4);
        chk_out("R6 press interrupt", 1'b1, 1'b0);
        wait_ticks(16);
        chk_out("R8 held press keeps irq", 1'b1, 1'b0);
        pb_n = 1'b1;
        wait_ticks(5);
        chk_out("R8 minimum width", 1'b1, 1'b0);
        wait_ticks(15);
        chk_out("R8 irq ends", 1'b1, 1'b1);
    endtask

    task automatic t_uv_irq();
        uv_ok = 1'b0;
        wait_ticks(30);
        chk_out("R7 short uv", 1'b1, 1'b1);
        wait_ticks(4);
        chk_out("R7 uv interrupt", 1'b1, 1'b0);
        wait_ticks(6);
        uv_ok = 1'b1;
        wait_ticks(10);
        chk_out("R8 minimum width after uv", 1'b1, 1'b0);
        wait_ticks(20);
        chk_out("R8 irq ends after uv", 1'b1, 1'b1);
    endtask

    task automatic t_long_press();
        pb_n = 1'b0;
        wait_ticks(78);
        chk_out("R9 before forced off", 1'b1, 1'b0);
        wait_ticks(4);
        chk_out("R9 forced off by press", 1'b0, 1'b1);
        wait_ticks(40);
        chk_out("R10 held press after off", 1'b0, 1'b1);
        pb_n = 1'b1;
        wait_ticks(2);
    endtask

    task automatic t_long_uv();
        uv_ok = 1'b0;
        wait_ticks(78);
        chk_out("R9 before uv forced off", 1'b1, 1'b0);
        wait_ticks(4);
        chk_out("R9 forced off by uv", 1'b0, 1'b1);
        uv_ok = 1'b1;
        wait_ticks(2);
    endtask

    task automatic t_kill_normal();
        kill_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_out("R5 kill in normal", 1'b0, 1'b1);
    endtask

    task automatic t_kill_in_irq();
        pb_n = 1'b0;
        wait_ticks(36);
        chk_out("R5 irq before kill", 1'b1, 1'b0);
        kill_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_out("R5 kill during irq", 1'b0, 1'b1);
        pb_n = 1'b1;
        wait_ticks(2);
    endtask

    initial begin
        t_reset();
        t_lockout();
        t_turn_on_kill_low();
        power_up();
        t_press_irq();
        t_uv_irq();
        t_long_press();
        power_up();
        t_long_uv();
        power_up();
        t_kill_normal();
        power_up();
        t_kill_in_irq();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule